// File: doc/BRIEF.md
# Bidirectional Bus Shift Register

An eight-stage storage register placed between two 8-bit buses, called A and B. One direction input picks which bus feeds the register and which bus the register drives. A parallel/serial input picks between whole-word transfers and bit-by-bit shifting. The block can pass a word from one bus to the other, assemble a serial stream into a word and present it on either bus, keep its word unchanged, or take a word from a bus and shift it out of its serial output.

In parallel mode a word can be loaded on the clock edge. It can also be let through transparently, so the stored word follows the input bus without waiting for a clock. Each bus is modelled as separate input, output and output-enable vectors; the tri-state drivers sit outside the block. The serial output is the top stage, so several registers can be chained into a longer one.

Top module: `bus_shift_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all stages clear to zero. The reset is synchronous and takes priority over every mode.
- R2: With `par_mode`=1, `async_sel`=0, `dir_a2b`=1 and `a_en`=1, the word on `a_in` is stored at the rising edge. It appears on `b_out` after that edge and not before.
- R3: With `par_mode`=1, `async_sel`=0 and `dir_a2b`=0, the word on `b_in` is stored at the rising edge whatever the level of `a_en`. It appears on `a_out` after that edge.
- R4: With `par_mode`=1, `async_sel`=1 and a loading source selected (as in R2 or R3), the outputs follow the selected input bus with no clock edge. When the mode is left, the word captured at the last rising edge inside the mode remains.
- R5: With `par_mode`=1, `dir_a2b`=1 and `a_en`=0, the stored word is kept at every edge. `a_in` and `async_sel` have no effect on it.
- R6: With `par_mode`=0, each rising edge shifts the word one place toward bit 7 and puts `ser_in` into bit 0. `async_sel` has no effect in this mode.
- R7: `ser_out` always equals bit 7 of the word shown on the outputs. A second register fed from it therefore receives the first register's bits in order.
- R8: `b_oe` is 1 exactly when `dir_a2b` is 1, and `b_out` carries the stored (or passed-through) word.
- R9: `a_oe` is 1 exactly when `dir_a2b` is 0 and `a_en` is 1, and `a_out` carries the same word as `b_out`. The two enables are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_mode | input | 1 | 1 selects parallel transfers, 0 selects serial shifting |
| async_sel | input | 1 | In parallel mode, 1 selects the transparent pass-through load |
| dir_a2b | input | 1 | 1: A is the input side and B is the output side; 0: the reverse |
| a_en | input | 1 | Gates the A side, both for loading and for driving |
| ser_in | input | 1 | Serial data entering bit 0 |
| a_in | input | 8 | Word sampled from bus A |
| a_out | output | 8 | Word offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Word sampled from bus B |
| b_out | output | 8 | Word offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |
| ser_out | output | 1 | Bit 7, for chaining registers |

## Verification
The bench checks that a clocked load does not show up on the outputs before its edge. A design that loads combinationally would fail there. It holds the register in recirculate mode while toggling `a_in` and `async_sel`; a design that lets the A bus in when A is disabled would change its word. The pass-through test moves the input bus between edges and then leaves the mode. This catches both a design that ignores transparency and one that keeps a word never seen at an edge. Serial tests run with `async_sel` high and feed a second chained register, so a reversed shift direction, a wrong serial-out bit or an asynchronous serial load all show up.

// File: rtl/bsr_pkg.sv
// Shared types for the bidirectional bus shift register.
// Assumes: consumed by all bsr_* modules; carries no state.
package bsr_pkg;
    // Operation the stage array performs this cycle.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,  // recirculate the stored word
        OP_LOAD  = 2'd1,  // capture the parallel word at the edge
        OP_SHIFT = 2'd2,  // shift toward the top stage
        OP_PASS  = 2'd3   // transparent: output follows the input bus
    } op_t;
endpackage

// File: rtl/bsr_ctrl.sv
// Control decoder: turns the mode pins into one stage operation and the
// two bus drive enables.
// Assumes: all inputs are synchronous to the register clock; purely combinational.
module bsr_ctrl
    import bsr_pkg::*;
(
    input  logic par_mode,
    input  logic async_sel,
    input  logic dir_a2b,
    input  logic a_en,
    output op_t  op,
    output logic a_oe,
    output logic b_oe
);
    logic src_open;

    // The B side is always usable; the A side only while it is enabled.
    assign src_open = dir_a2b ? a_en : 1'b1;

    // Select the stage operation; serial mode ignores async_sel.
    always_comb begin
        if (!par_mode) begin
            op = OP_SHIFT;
        end else if (!src_open) begin
            op = OP_HOLD;
        end else if (async_sel) begin
            op = OP_PASS;
        end else begin
            op = OP_LOAD;
        end
    end

    // Drive enables: B drives when it is the output side, A also needs a_en.
    always_comb begin
        b_oe = dir_a2b;
        a_oe = !dir_a2b && a_en;
    end
endmodule

// File: rtl/bsr_stages.sv
// Stage array: W single-bit storage stages, each with its own next-value
// mux, plus the transparent view used in pass-through mode.
// Assumes: op is stable around the clock edge; rst_n is synchronous.
module bsr_stages
    import bsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  op_t          op,
    input  logic [W-1:0] par_word,
    input  logic         ser_in,
    output logic [W-1:0] view
);
    logic [W-1:0] q;
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic shift_src;

        // Bit 0 takes the serial input; higher bits take their lower neighbour.
        if (i == 0) begin : g_first
            assign shift_src = ser_in;
        end else begin : g_rest
            assign shift_src = q[i-1];
        end

        // Next value for this stage according to the current operation.
        always_comb begin
            unique case (op)
                OP_HOLD:  nxt[i] = q[i];
                OP_SHIFT: nxt[i] = shift_src;
                default:  nxt[i] = par_word[i];
            endcase
        end

        // Stage flip-flop with synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= nxt[i];
            end
        end

        // Visible bit: the input itself while transparent, else the stored bit.
        assign view[i] = (op == OP_PASS) ? par_word[i] : q[i];
    end
endmodule

// File: rtl/bsr_port_mux.sv
// Bus steering: picks the source bus for parallel loads and fans the
// register word out to both bus outputs and the serial output.
// Assumes: the drive enables come from bsr_ctrl; purely combinational.
module bsr_port_mux #(
    parameter int W = 8
) (
    input  logic         dir_a2b,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] view,
    output logic [W-1:0] par_word,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         ser_out
);
    // Source select: A feeds the register when the direction is A to B.
    assign par_word = dir_a2b ? a_in : b_in;

    // Both buses are offered the same word; the enables decide who drives.
    assign a_out   = view;
    assign b_out   = view;
    assign ser_out = view[W-1];
endmodule

// File: rtl/bus_shift_reg.sv
// Bidirectional bus shift register, top level: wires the control decoder,
// the bus steering and the stage array together.
// Assumes: buses are split into in/out/oe vectors; tri-states live outside.
module bus_shift_reg
    import bsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par_mode,
    input  logic         async_sel,
    input  logic         dir_a2b,
    input  logic         a_en,
    input  logic         ser_in,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         ser_out
);
    op_t          op;
    logic [W-1:0] par_word;
    logic [W-1:0] view;

    bsr_ctrl u_ctrl (
        .par_mode (par_mode),
        .async_sel(async_sel),
        .dir_a2b  (dir_a2b),
        .a_en     (a_en),
        .op       (op),
        .a_oe     (a_oe),
        .b_oe     (b_oe)
    );

    bsr_port_mux #(.W(W)) u_mux (
        .dir_a2b (dir_a2b),
        .a_in    (a_in),
        .b_in    (b_in),
        .view    (view),
        .par_word(par_word),
        .a_out   (a_out),
        .b_out   (b_out),
        .ser_out (ser_out)
    );

    bsr_stages #(.W(W)) u_stages (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .par_word(par_word),
        .ser_in  (ser_in),
        .view    (view)
    );
endmodule

// File: rtl/bsr_chk.sv
// Assertion checker for bus_shift_reg, attached by bind below.
// Assumes: observes top-level ports only.
module bsr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         par_mode,
    input logic         async_sel,
    input logic         dir_a2b,
    input logic         a_en,
    input logic         ser_in,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         ser_out
);
    logic pass_now;
    assign pass_now = par_mode && async_sel && (dir_a2b ? a_en : 1'b1);

    // R2
    a2b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && par_mode && !async_sel && dir_a2b && a_en) && !pass_now)
            |-> b_out == $past(a_in));

    // R3
    b2a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && par_mode && !async_sel && !dir_a2b) && !pass_now)
            |-> a_out == $past(b_in));

    // R4
    pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_mode && async_sel && dir_a2b && a_en) |-> b_out == a_in);

    // R5
    recirc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && par_mode && dir_a2b && !a_en) && par_mode && dir_a2b && !a_en)
            |-> $stable(b_out));

    // R6
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && !par_mode) && !par_mode)
            |-> b_out == {$past(b_out[W-2:0]), $past(ser_in)});

    // R7
    ser_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out == b_out[W-1]);

    // R8
    b_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe == dir_a2b);

    // R9
    a_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe |-> (!dir_a2b && a_en && a_out == b_out));

    // R9
    oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_oe, b_oe}));
endmodule

bind bus_shift_reg bsr_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .async_sel(async_sel),
    .dir_a2b  (dir_a2b),
    .a_en     (a_en),
    .ser_in   (ser_in),
    .a_in     (a_in),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b_in     (b_in),
    .b_out    (b_out),
    .b_oe     (b_oe),
    .ser_out  (ser_out)
);

// File: tb/tb_bus_shift_reg.sv
// Directed bench for bus_shift_reg: one task per scenario, each checking
// its own results against values derived from the requirements.
module tb_bus_shift_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, par_mode, async_sel, dir_a2b, a_en, ser_in;
    logic [W-1:0] a_in, b_in, a_out, b_out, a_out2, b_out2;
    logic         a_oe, b_oe, ser_out, a_oe2, b_oe2, ser_out2;
    int           n_chk = 0;
    int           n_err = 0;
    logic [W-1:0] exp_w;

    always #10 clk = ~clk;  // 50 MHz

    bus_shift_reg #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .async_sel(async_sel),
        .dir_a2b(dir_a2b), .a_en(a_en), .ser_in(ser_in),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
    );

    // Second register chained on the first one's serial output (R7).
    bus_shift_reg #(.W(W)) dut_hi (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .async_sel(async_sel),
        .dir_a2b(dir_a2b), .a_en(a_en), .ser_in(ser_out),
        .a_in(a_in), .a_out(a_out2), .a_oe(a_oe2),
        .b_in(b_in), .b_out(b_out2), .b_oe(b_oe2), .ser_out(ser_out2)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: edge, then settle to the falling edge before sampling.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; par_mode = 1'b0; ser_in = 1'b1; async_sel = 1'b0;
        dir_a2b = 1'b1; a_en = 1'b0;
        tick();
        chk("R1 reset clears word", b_out, '0);
        chk("R1 reset clears serial out", {7'b0, ser_out}, '0);
        chk("R8 b_oe with dir high", {7'b0, b_oe}, 8'd1);
        chk("R9 a_oe with dir high", {7'b0, a_oe}, 8'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_load_a2b(input logic [W-1:0] w);
        par_mode = 1'b1; async_sel = 1'b0; dir_a2b = 1'b1; a_en = 1'b1; a_in = w;
        #1;
        chk("R2 no change before edge", b_out, exp_w);
        tick();
        exp_w = w;
        chk("R2 A to B load", b_out, w);
        chk("R8 b_oe on A to B", {7'b0, b_oe}, 8'd1);
        chk("R9 a_oe off on A to B", {7'b0, a_oe}, 8'd0);
    endtask

    task automatic t_load_b2a(input logic [W-1:0] w, input logic en);
        par_mode = 1'b1; async_sel = 1'b0; dir_a2b = 1'b0; a_en = en; b_in = w;
        a_in = ~w;
        tick();
        exp_w = w;
        chk("R3 B to A load", a_out, w);
        chk("R9 a_oe follows a_en", {7'b0, a_oe}, {7'b0, en});
        chk("R8 b_oe off on B to A", {7'b0, b_oe}, 8'd0);
    endtask

    task automatic t_hold();
        par_mode = 1'b1; dir_a2b = 1'b1; a_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            async_sel = k[0];
            a_in = 8'h3C ^ k[7:0];
            #1;
            chk("R5 hold ignores a_in between edges", b_out, exp_w);
            tick();
            chk("R5 recirculate keeps word", b_out, exp_w);
        end
    endtask

    task automatic t_pass();
        par_mode = 1'b1; async_sel = 1'b1; dir_a2b = 1'b1; a_en = 1'b1;
        a_in = 8'h96;
        #1;
        chk("R4 pass-through without clock", b_out, 8'h96);
        a_in = 8'h21;
        #1;
        chk("R4 pass-through follows change", b_out, 8'h21);
        tick();
        a_in = 8'hE7;
        #1;
        chk("R4 pass-through after edge", b_out, 8'hE7);
        a_en = 1'b0;
        #1;
        exp_w = 8'h21;
        chk("R4 leaves word captured at last edge", b_out, 8'h21);
        tick();
        chk("R5 hold after pass-through", b_out, 8'h21);
    endtask

    task automatic t_shift(input logic [W-1:0] bits);
        logic [W-1:0] hi_exp;
        par_mode = 1'b0; async_sel = 1'b1; dir_a2b = 1'b1; a_en = 1'b1;
        hi_exp = b_out2;
        for (int k = 0; k < W; k++) begin
            ser_in = bits[k];
            b_in = 8'hFF; a_in = 8'hFF;
            hi_exp = {hi_exp[W-2:0], exp_w[W-1]};
            tick();
            exp_w = {exp_w[W-2:0], bits[k]};
            chk("R6 serial shift", b_out, exp_w);
            chk("R7 serial out is bit 7", {7'b0, ser_out}, {7'b0, exp_w[W-1]});
        end
        chk("R7 chained register receives upper bits", b_out2, hi_exp);
        dir_a2b = 1'b0; a_en = 1'b0;
        #1;
        chk("R9 A off when a_en low in serial", {7'b0, a_oe}, 8'd0);
        a_en = 1'b1;
        #1;
        chk("R9 A drives stored word", a_out, exp_w);
    endtask

    initial begin
        rst_n = 1'b0; par_mode = 1'b0; async_sel = 1'b0; dir_a2b = 1'b1;
        a_en = 1'b0; ser_in = 1'b0; a_in = '0; b_in = '0;
        exp_w = '0;
        tick();
        t_reset();
        t_load_a2b(8'hA5);
        t_load_a2b(8'h5A);
        t_load_b2a(8'hC3, 1'b0);
        t_load_b2a(8'h0F, 1'b1);
        t_hold();
        t_pass();
        t_shift(8'b0100_1101);
        t_load_a2b(8'hFF);
        t_shift(8'b1010_0110);
        t_reset();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule